// File: doc/BRIEF.md
# Subpage Fill Sequencer with Bounded Prefetch

This block moves subpages from a slow non-volatile backing store into a DRAM page cache. A subpage is the smallest unit it moves. When the cache misses, the requester presents a page index, a subpage index and a prefetch depth. The block fetches the missing subpage first. It then uses the cycles in which the backing-store channel would otherwise be idle to fetch up to the requested number of following subpages of the same page.

Before each prefetch, the block queries the page's valid bitmap. Subpages that are already resident are skipped and do not use the channel. A subpage transfer that has started always runs to completion. A demand that arrives during a transfer waits for it to finish. When the channel frees up, that demand takes precedence and discards whatever prefetch work was still outstanding.

The backing-store channel is modelled by a latency counter. It applies an initial read latency, then delivers 128-bit beats at a fixed spacing. Each beat is forwarded to the cache write side. A one-cycle fill strobe marks the end of each subpage so that its valid bit can be set.

Top module: `subpage_prefetch_ctrl`

## Requirements
- R1: After reset, `dm_ready` is 1, and `xfer_start`, `xfer_busy`, `wr_valid` and `fill_valid` are 0.
- R2: A demand presented while `dm_ready` is 1 is accepted at the next clock edge. `xfer_start` is then high for one cycle with the demanded page and subpage, and `xfer_prefetch` is 0.
- R3: Let N = INIT_LAT + BEATS*BEAT_CYC, where BEATS = SUB_BYTES*8/BUS_W. With the defaults 300, 3, 512 and 128, BEATS is 32 and N is 396. For every transfer, `fill_valid` rises N cycles after `xfer_start`. `wr_valid` pulses BEATS times, the first pulse INIT_LAT+BEAT_CYC cycles after `xfer_start`. Each `wr_data` equals the `rd_data` present in the cycle before.
- R4: The prefetch window is subpages s+1 to s+K of the demanded page, where s is the demanded subpage and K is the `pf_count` latched when the demand is accepted. These subpages are examined in ascending order. A prefetch starts (`xfer_prefetch` = 1) one cycle after the previous fill plus one cycle per skipped subpage. When K is 0, nothing is prefetched.
- R5: Once started, a transfer is never cut short. `dm_ready` is 0 and `xfer_busy` is 1 until it completes. A demand raised mid-transfer does not move the fill time.
- R6: A demand pending when a transfer completes starts one cycle after that fill. The rest of the old prefetch window is discarded and never fetched.
- R7: Prefetch never crosses a page boundary. No subpage above index 2^SUB_W-1 (63 by default) is fetched, and the window never wraps to subpage 0.
- R8: A window subpage for which `q_hit` is 1 is not transferred. It costs one cycle and still counts toward K.
- R9: `fill_valid` is a one-cycle pulse per completed transfer. It carries that transfer's page, subpage and prefetch flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dm_valid | input | 1 | Demand miss request pending |
| dm_page | input | PAGE_W | Page index of the demand |
| dm_sub | input | SUB_W | Subpage index of the demand |
| pf_count | input | CNT_W | Number of following subpages to prefetch |
| dm_ready | output | 1 | Channel free; a pending demand is taken this edge |
| q_page | output | PAGE_W | Bitmap query page |
| q_sub | output | SUB_W | Bitmap query subpage |
| q_hit | input | 1 | Queried subpage already valid |
| rd_data | input | BUS_W | Beat data from the backing store |
| xfer_start | output | 1 | One-cycle pulse: transfer launched |
| xfer_busy | output | 1 | Channel transfer in progress |
| xfer_page | output | PAGE_W | Page of the current transfer |
| xfer_sub | output | SUB_W | Subpage of the current transfer |
| xfer_prefetch | output | 1 | Current transfer is a prefetch |
| wr_valid | output | 1 | Beat write to the page cache |
| wr_beat | output | $clog2(BEATS) | Beat index within the subpage |
| wr_data | output | BUS_W | Beat data to the page cache |
| fill_valid | output | 1 | Subpage fill complete |
| fill_page | output | PAGE_W | Page of the completed fill |
| fill_sub | output | SUB_W | Subpage of the completed fill |
| fill_prefetch | output | 1 | Completed fill was a prefetch |

## Verification
The bench steers demands into the last two subpages of a page. A design that wraps or runs past the boundary would show an extra transfer at subpage 0 or 64. It also presents windows that contain resident subpages. A design that fetches them anyway, or that does not charge them against the depth, would show extra or shifted transfers, and a skip that costs the wrong number of cycles would move every later start time. A second demand raised in the middle of a transfer with a deep window checks two things. An interruptible design would fill early. A design that lets the old window outrank the new demand would launch a prefetch of the old page before or after it. Beat count, beat spacing and forwarded data are checked on every transfer, so an off-by-one in the latency counter shows up in each fill time.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef enum logic {
    S_WAIT = 1'b0,
    S_XFER = 1'b1
  } spf_state_e;
endpackage

// File: rtl/spf_chan_timer.sv
module spf_chan_timer #(
  parameter int INIT_LAT = 300,
  parameter int BEAT_CYC = 3,
  parameter int BEATS    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic                     busy,
  output logic                     beat,
  output logic                     last,
  output logic [$clog2(BEATS)-1:0] beat_idx
);
  localparam int LAT_W = $clog2(INIT_LAT + 1);
  localparam int CYC_W = $clog2(BEAT_CYC + 1);
  localparam int IDX_W = $clog2(BEATS);

  logic             busy_q, busy_d;
  logic             lat_ph_q, lat_ph_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign beat     = busy_q && !lat_ph_q && (cyc_q == '0);
  assign last     = beat && (idx_q == IDX_W'(BEATS - 1));
  assign busy     = busy_q;
  assign beat_idx = idx_q;

  always_comb begin
    busy_d   = busy_q;
    lat_ph_d = lat_ph_q;
    lat_d    = lat_q;
    cyc_d    = cyc_q;
    idx_d    = idx_q;
    if (start) begin
      busy_d   = 1'b1;
      lat_ph_d = 1'b1;
      lat_d    = LAT_W'(INIT_LAT - 1);
      cyc_d    = CYC_W'(BEAT_CYC - 1);
      idx_d    = '0;
    end else if (busy_q) begin
      if (lat_ph_q) begin
        if (lat_q == '0) lat_ph_d = 1'b0;
        else             lat_d    = lat_q - 1'b1;
      end else if (cyc_q == '0) begin
        cyc_d = CYC_W'(BEAT_CYC - 1);
        idx_d = idx_q + 1'b1;
        if (last) busy_d = 1'b0;
      end else begin
        cyc_d = cyc_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      lat_ph_q <= 1'b0;
      lat_q    <= '0;
      cyc_q    <= '0;
      idx_q    <= '0;
    end else begin
      busy_q   <= busy_d;
      lat_ph_q <= lat_ph_d;
      lat_q    <= lat_d;
      cyc_q    <= cyc_d;
      idx_q    <= idx_d;
    end
  end

  // R5: a running transfer is never restarted by the sequencer
  p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
endmodule

// File: rtl/spf_pf_window.sv
module spf_pf_window #(
  parameter int SUB_W = 6,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SUB_W-1:0] load_sub,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             adv,
  output logic [SUB_W-1:0] cur_sub,
  output logic             more
);
  // one extra bit flags the step past the last subpage of the page
  logic [SUB_W:0]   nxt_q, nxt_d;
  logic [CNT_W-1:0] left_q, left_d;

  assign cur_sub = nxt_q[SUB_W-1:0];
  assign more    = (left_q != '0) && !nxt_q[SUB_W];

  always_comb begin
    nxt_d  = nxt_q;
    left_d = left_q;
    if (load) begin
      nxt_d  = {1'b0, load_sub} + (SUB_W + 1)'(1);
      left_d = load_cnt;
    end else if (adv) begin
      nxt_d  = nxt_q + (SUB_W + 1)'(1);
      left_d = left_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_q  <= '0;
      left_q <= '0;
    end else begin
      nxt_q  <= nxt_d;
      left_q <= left_d;
    end
  end

  // R7: the window is only stepped while it still lies inside the page
  p_adv_in_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> more);
endmodule

// File: rtl/subpage_prefetch_ctrl.sv
module subpage_prefetch_ctrl
  import spf_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int SUB_W     = 6,
  parameter int CNT_W     = 3,
  parameter int BUS_W     = 128,
  parameter int SUB_BYTES = 512,
  parameter int INIT_LAT  = 300,
  parameter int BEAT_CYC  = 3
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     dm_valid,
  input  logic [PAGE_W-1:0]                        dm_page,
  input  logic [SUB_W-1:0]                         dm_sub,
  input  logic [CNT_W-1:0]                         pf_count,
  output logic                                     dm_ready,
  output logic [PAGE_W-1:0]                        q_page,
  output logic [SUB_W-1:0]                         q_sub,
  input  logic                                     q_hit,
  input  logic [BUS_W-1:0]                         rd_data,
  output logic                                     xfer_start,
  output logic                                     xfer_busy,
  output logic [PAGE_W-1:0]                        xfer_page,
  output logic [SUB_W-1:0]                         xfer_sub,
  output logic                                     xfer_prefetch,
  output logic                                     wr_valid,
  output logic [$clog2(SUB_BYTES*8/BUS_W)-1:0]     wr_beat,
  output logic [BUS_W-1:0]                         wr_data,
  output logic                                     fill_valid,
  output logic [PAGE_W-1:0]                        fill_page,
  output logic [SUB_W-1:0]                         fill_sub,
  output logic                                     fill_prefetch
);
  localparam int BEATS  = SUB_BYTES * 8 / BUS_W;
  localparam int BEAT_W = $clog2(BEATS);

  spf_state_e        state_q, state_d;
  logic [PAGE_W-1:0] page_q;
  logic [SUB_W-1:0]  sub_q;
  logic              pf_q;
  logic              start_q;
  logic              fill_q, fill_pf_q;
  logic [PAGE_W-1:0] fill_page_q;
  logic [SUB_W-1:0]  fill_sub_q;
  logic              wr_q;
  logic [BEAT_W-1:0] wr_beat_q;
  logic [BUS_W-1:0]  wr_data_q;

  logic              chan_busy, chan_beat, chan_last;
  logic [BEAT_W-1:0] chan_idx;
  logic [SUB_W-1:0]  win_sub;
  logic              win_more;
  logic              take_dm, pf_ok, issue;

  // demand outranks any prefetch not yet launched
  assign take_dm = dm_valid && (state_q == S_WAIT);
  assign pf_ok   = (state_q == S_WAIT) && !dm_valid && win_more;
  assign issue   = take_dm || (pf_ok && !q_hit);

  spf_pf_window #(.SUB_W(SUB_W), .CNT_W(CNT_W)) u_win (
    .clk(clk), .rst_n(rst_n),
    .load(take_dm), .load_sub(dm_sub), .load_cnt(pf_count),
    .adv(pf_ok), .cur_sub(win_sub), .more(win_more)
  );

  spf_chan_timer #(.INIT_LAT(INIT_LAT), .BEAT_CYC(BEAT_CYC), .BEATS(BEATS)) u_chan (
    .clk(clk), .rst_n(rst_n), .start(issue),
    .busy(chan_busy), .beat(chan_beat), .last(chan_last), .beat_idx(chan_idx)
  );

  always_comb begin
    state_d = state_q;
    if (issue)                                 state_d = S_XFER;
    else if (state_q == S_XFER && chan_last)   state_d = S_WAIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_WAIT;
      page_q      <= '0;
      sub_q       <= '0;
      pf_q        <= 1'b0;
      start_q     <= 1'b0;
      fill_q      <= 1'b0;
      fill_pf_q   <= 1'b0;
      fill_page_q <= '0;
      fill_sub_q  <= '0;
      wr_q        <= 1'b0;
      wr_beat_q   <= '0;
      wr_data_q   <= '0;
    end else begin
      state_q <= state_d;
      start_q <= issue;
      fill_q  <= chan_last;
      wr_q    <= chan_beat;
      if (issue) begin
        page_q <= take_dm ? dm_page : page_q;
        sub_q  <= take_dm ? dm_sub : win_sub;
        pf_q   <= !take_dm;
      end
      if (chan_last) begin
        fill_page_q <= page_q;
        fill_sub_q  <= sub_q;
        fill_pf_q   <= pf_q;
      end
      if (chan_beat) begin
        wr_beat_q <= chan_idx;
        wr_data_q <= rd_data;
      end
    end
  end

  assign dm_ready      = (state_q == S_WAIT);
  assign q_page        = page_q;
  assign q_sub         = win_sub;
  assign xfer_start    = start_q;
  assign xfer_busy     = chan_busy;
  assign xfer_page     = page_q;
  assign xfer_sub      = sub_q;
  assign xfer_prefetch = pf_q;
  assign wr_valid      = wr_q;
  assign wr_beat       = wr_beat_q;
  assign wr_data       = wr_data_q;
  assign fill_valid    = fill_q;
  assign fill_page     = fill_page_q;
  assign fill_sub      = fill_sub_q;
  assign fill_prefetch = fill_pf_q;

  // R5: the transfer target is frozen until the channel finishes
  p_hold_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_busy && !chan_last) |=> (chan_busy && $stable(page_q) && $stable(sub_q)));
  // R6: a demand seen on a free channel is launched next, ahead of prefetch
  p_demand_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT && dm_valid) |=> (xfer_start && !xfer_prefetch));
  // R7: prefetch stays in the page and moves strictly upward
  p_same_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && xfer_prefetch) |-> ($stable(xfer_page) && (xfer_sub > $past(xfer_sub))));
  // R8: a prefetch is only launched for a subpage reported as not valid
  p_skip_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && xfer_prefetch) |-> !$past(q_hit));
  // R9: fill strobe lasts exactly one cycle
  p_fill_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !fill_valid);
endmodule

// File: tb/sim_subpage_prefetch_ctrl.sv
`timescale 1ns/1ps
module sim_subpage_prefetch_ctrl;
  localparam int INIT_LAT = 300;
  localparam int BEAT_CYC = 3;
  localparam int BEATS    = 512 * 8 / 128;
  localparam int N        = INIT_LAT + BEATS * BEAT_CYC;
  localparam int WD_LIMIT = 150000;
  localparam int NROWS    = 7;
  // {page[80:73], sub[72:67], pf_count[66:64], valid mask[63:0]}
  localparam logic [80:0] VEC [NROWS] = '{
    {8'h12, 6'd5,  3'd1, 64'h0},
    {8'h34, 6'd10, 3'd3, 64'h0},
    {8'h56, 6'd62, 3'd3, 64'h0},
    {8'h78, 6'd63, 3'd2, 64'h0},
    {8'h9A, 6'd20, 3'd4, 64'h0000_0000_00A0_0000},
    {8'hBC, 6'd0,  3'd0, 64'h0},
    {8'hDE, 6'd40, 3'd2, 64'h0000_0600_0000_0000}
  };

  logic         clk, rst_n;
  logic         dm_valid, dm_ready, q_hit;
  logic [7:0]   dm_page, q_page, xfer_page, fill_page;
  logic [5:0]   dm_sub, q_sub, xfer_sub, fill_sub;
  logic [2:0]   pf_count;
  logic [127:0] rd_data, wr_data;
  logic         xfer_start, xfer_busy, xfer_prefetch;
  logic         wr_valid, fill_valid, fill_prefetch;
  logic [4:0]   wr_beat;
  logic [7:0]   bm_page;
  logic [63:0]  bm_mask;

  int cyc, n_tests, n_fail;
  int n_st, n_fl, beat_cnt, first_beat, data_err;
  int st_cyc[16], st_sub[16], st_page[16], st_pf[16];
  int fl_cyc[16], fl_sub[16], fl_page[16], fl_pf[16], fl_beats[16], fl_first[16];

  function automatic logic [127:0] pat(int c);
    return {4{32'(c) ^ 32'h5A5A_0000}};
  endfunction

  assign rd_data = pat(cyc);
  assign q_hit   = (q_page == bm_page) && bm_mask[q_sub];

  subpage_prefetch_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .dm_valid(dm_valid), .dm_page(dm_page), .dm_sub(dm_sub),
    .pf_count(pf_count), .dm_ready(dm_ready), .q_page(q_page), .q_sub(q_sub),
    .q_hit(q_hit), .rd_data(rd_data), .xfer_start(xfer_start), .xfer_busy(xfer_busy),
    .xfer_page(xfer_page), .xfer_sub(xfer_sub), .xfer_prefetch(xfer_prefetch),
    .wr_valid(wr_valid), .wr_beat(wr_beat), .wr_data(wr_data), .fill_valid(fill_valid),
    .fill_page(fill_page), .fill_sub(fill_sub), .fill_prefetch(fill_prefetch)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // transfer log, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (xfer_start) begin
        if (n_st < 16) begin
          st_cyc[n_st] = cyc; st_sub[n_st] = int'(xfer_sub);
          st_page[n_st] = int'(xfer_page); st_pf[n_st] = int'(xfer_prefetch);
        end
        n_st++;
        beat_cnt = 0;
        first_beat = -1;
      end
      if (wr_valid) begin
        if (beat_cnt == 0) first_beat = cyc;
        beat_cnt++;
        if (wr_data != pat(cyc - 1)) data_err++;
      end
      if (fill_valid) begin
        if (n_fl < 16) begin
          fl_cyc[n_fl] = cyc; fl_sub[n_fl] = int'(fill_sub);
          fl_page[n_fl] = int'(fill_page); fl_pf[n_fl] = int'(fill_prefetch);
          fl_beats[n_fl] = beat_cnt; fl_first[n_fl] = first_beat;
        end
        n_fl++;
      end
    end
    if (cyc > WD_LIMIT) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  task automatic demand(input logic [7:0] pg, input logic [5:0] sb,
                        input logic [2:0] cn, output int dcyc);
    @(negedge clk);
    dm_valid = 1'b1; dm_page = pg; dm_sub = sb; pf_count = cn;
    while (!dm_ready) @(negedge clk);
    dcyc = cyc;
    @(negedge clk);
    dm_valid = 1'b0;
  endtask

  function automatic string row_tag(int r);
    case (r)
      2, 3:    return "R7";
      4, 6:    return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic run_row(int r);
    logic [7:0]  pg;
    logic [5:0]  sb;
    logic [2:0]  cn;
    logic [63:0] mk;
    int dcyc, e_n, skip, es[8], ek[8];
    string tg;
    {pg, sb, cn, mk} = VEC[r];
    tg = row_tag(r);
    bm_page = pg; bm_mask = mk;
    n_st = 0; n_fl = 0;
    demand(pg, sb, cn, dcyc);
    repeat ((int'(cn) + 1) * (N + 2) + 20) @(negedge clk);
    #1;
    e_n = 1; es[0] = int'(sb); ek[0] = 0; skip = 0;
    for (int j = 1; j <= int'(cn); j++) begin
      if (int'(sb) + j > 63) break;
      if (mk[int'(sb) + j]) skip++;
      else begin es[e_n] = int'(sb) + j; ek[e_n] = skip; skip = 0; e_n++; end
    end
    chk(tg, $sformatf("row %0d transfer count", r), n_st, e_n);
    chk("R9", $sformatf("row %0d fill count", r), n_fl, e_n);
    for (int i = 0; i < e_n && i < n_st && i < n_fl; i++) begin
      if (i == 0) begin
        chk("R2", $sformatf("row %0d demand start cycle", r), st_cyc[0], dcyc + 1);
        chk("R2", $sformatf("row %0d demand flag", r), st_pf[0], 0);
      end else begin
        chk(tg, $sformatf("row %0d prefetch %0d start cycle", r, i), st_cyc[i], st_cyc[i-1] + N + 1 + ek[i]);
        chk("R4", $sformatf("row %0d prefetch %0d flag", r, i), st_pf[i], 1);
      end
      chk(tg, $sformatf("row %0d transfer %0d subpage", r, i), st_sub[i], es[i]);
      chk("R7", $sformatf("row %0d transfer %0d page", r, i), st_page[i], int'(pg));
      chk("R3", $sformatf("row %0d transfer %0d fill cycle", r, i), fl_cyc[i], st_cyc[i] + N);
      chk("R3", $sformatf("row %0d transfer %0d beats", r, i), fl_beats[i], BEATS);
      chk("R3", $sformatf("row %0d transfer %0d first beat", r, i), fl_first[i], st_cyc[i] + INIT_LAT + BEAT_CYC);
      chk("R9", $sformatf("row %0d fill %0d subpage", r, i), fl_sub[i], es[i]);
      chk("R9", $sformatf("row %0d fill %0d page", r, i), fl_page[i], int'(pg));
      chk("R9", $sformatf("row %0d fill %0d flag", r, i), fl_pf[i], (i == 0) ? 0 : 1);
    end
  endtask

  initial begin
    int d0, s0;
    cyc = 0; n_tests = 0; n_fail = 0; n_st = 0; n_fl = 0;
    beat_cnt = 0; first_beat = -1; data_err = 0;
    rst_n = 1'b0; dm_valid = 1'b0; dm_page = '0; dm_sub = '0; pf_count = '0;
    bm_page = '0; bm_mask = '0;
    repeat (4) @(negedge clk);
    chk("R1", "ready in reset", int'(dm_ready), 1);
    chk("R1", "busy in reset", int'(xfer_busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "start after reset", int'(xfer_start), 0);
    chk("R1", "fill after reset", int'(fill_valid), 0);
    chk("R1", "beat after reset", int'(wr_valid), 0);
    chk("R1", "ready after reset", int'(dm_ready), 1);

    for (int r = 0; r < NROWS; r++) run_row(r);

    // R5 / R6: demand mid-transfer waits, then replaces the old window
    bm_page = 8'h11; bm_mask = '0;
    n_st = 0; n_fl = 0;
    demand(8'h11, 6'd3, 3'd3, d0);
    s0 = d0 + 1;
    while (cyc < s0 + 100) @(negedge clk);
    chk("R5", "ready during transfer", int'(dm_ready), 0);
    chk("R5", "busy during transfer", int'(xfer_busy), 1);
    dm_valid = 1'b1; dm_page = 8'h22; dm_sub = 6'd7; pf_count = 3'd0;
    while (!dm_ready) @(negedge clk);
    @(negedge clk);
    dm_valid = 1'b0;
    repeat (3 * N) @(negedge clk);
    #1;
    chk("R5", "first fill cycle", fl_cyc[0], s0 + N);
    chk("R5", "first fill subpage", fl_sub[0], 3);
    chk("R6", "transfers after preempting demand", n_st, 2);
    chk("R6", "demand start cycle", st_cyc[1], s0 + N + 1);
    chk("R6", "demand subpage", st_sub[1], 7);
    chk("R6", "demand page", st_page[1], 8'h22);
    chk("R6", "demand flag", st_pf[1], 0);
    chk("R3", "data beat mismatches", data_err, 0);
    summary();
    $finish;
  end
endmodule